// File: doc/BRIEF.md
# Serial Converter Control-Word Transmitter

This block sends one 16-bit mode-control word at a time to an external audio converter over a three-wire control port: a serial data line, a bit clock and a latch strobe. A requester presents a 2-bit register index and a 9-bit payload on a valid/ready port. The block places the index in bits [10:9], fills bits [8:0] with the payload and clears the upper bits. It then clocks the word out most significant bit first, using a bit clock whose phase length is set by a parameter.

The strobe idles high and stays high through the whole shift. Once the last bit is out, the block drives the strobe low for one phase and then releases it high; that low pulse is what makes the converter commit the word. A busy flag covers the whole transfer. A one-cycle done pulse marks the cycle in which the strobe returns high, and the block can take the next request in that same cycle.

Top module: `dac_ctl_serializer`

## Requirements
- R1: The transmitted word has bits [10:9] equal to the request index, bits [8:0] equal to the payload and bits [15:11] equal to zero; it equals index*512 + payload.
- R2: Exactly 16 bits are sent per word, most significant first, with one rising bit-clock edge per bit; data is sampled by the receiver on that rising edge.
- R3: Each bit occupies three phases: data set with the bit clock low, bit clock high, bit clock low again. The data line holds the bit through all three phases.
- R4: Right after a request is accepted, one phase follows with data and bit clock both low and the strobe high, before the first bit's setup phase.
- R5: The strobe stays high from acceptance until the last bit's final phase ends. It is then low for exactly one phase, with the bit clock low, and then returns high.
- R6: Every phase lasts PHASE_CLKS system clocks. From the accepting clock edge to the cycle in which done is visible, a transfer takes 50*PHASE_CLKS cycles (1 lead-in phase, 48 bit phases, 1 latch phase).
- R7: Busy is high from the cycle after acceptance until the strobe returns high. While busy is high, ready is low, and a request held valid during that time has no effect on the word being sent.
- R8: Done is a single-cycle pulse. It is high in the cycle in which the strobe returns high and busy falls, and ready is high in that cycle.
- R9: After reset the strobe is high, data and bit clock are low, busy and done are low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on valid and ready |
| req_idx | input | IDX_W (2) | Register index placed at bits [10:9] |
| req_data | input | PAY_W (9) | Payload placed at bits [8:0] |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the word is latched |
| dac_dout | output | 1 | Serial data to the converter |
| dac_bclk | output | 1 | Bit clock to the converter |
| dac_strobe | output | 1 | Latch strobe, idle high, low pulse commits |

## Verification
The bench builds two copies of the block. The first uses PHASE_CLKS = 1, which keeps each transfer short enough to sweep all 4 indices against all 512 payloads. That sweep reconstructs each word from the rising bit-clock edges and compares it with the index*512 + payload value. The second uses PHASE_CLKS = 3, where phases span several cycles. With that copy, the exact phase lengths, the position of the first rising edge after the lead-in, the strobe pulse width and the total transfer length can be checked. Both copies are also fed requests held valid while busy, to show that these requests are ignored.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LEAD  = 3'd1,
      ST_SETUP = 3'd2,
      ST_HIGH  = 3'd3,
      ST_LOW   = 3'd4,
      ST_LATCH = 3'd5
   } dcs_state_e;

   localparam int unsigned PHASES_PER_BIT = 3;

   function automatic int unsigned total_phases(input int unsigned word_w);
      return 2 + PHASES_PER_BIT * word_w;
   endfunction

endpackage

// File: rtl/dcs_word_form.sv
module dcs_word_form #(
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned IDX_W   = 2,
   parameter int unsigned IDX_LSB = 9,
   parameter int unsigned PAY_W   = 9
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [PAY_W-1:0]  pay,
   output logic [WORD_W-1:0] word
);

   localparam int unsigned TOP_PAD = WORD_W - IDX_LSB - IDX_W;

   generate
      if (PAY_W > IDX_LSB) begin : g_overlap
         // payload reaches into the index field: fields are merged by OR
         always_comb begin
            word = WORD_W'(pay) | (WORD_W'(idx) << IDX_LSB);
         end
      end else if (TOP_PAD == 0) begin : g_flush
         always_comb begin
            word = (WORD_W'(idx) << IDX_LSB) | WORD_W'(pay);
         end
      end else begin : g_padded
         logic [TOP_PAD-1:0] pad;
         assign pad = '0;
         always_comb begin
            word = {pad, idx, {IDX_LSB{1'b0}}} | WORD_W'(pay);
         end
      end
   endgenerate

endmodule

// File: rtl/dcs_phase_timer.sv
module dcs_phase_timer #(
   parameter int unsigned PHASE_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   localparam int unsigned TC_W = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
   localparam logic [TC_W-1:0] LAST = TC_W'(PHASE_CLKS - 1);

   logic [TC_W-1:0] cnt_q;

   assign tick = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/dcs_shift_fsm.sv
module dcs_shift_fsm
   import dcs_pkg::*;
#(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] word,
   input  logic              tick,
   output logic              running,
   output logic              idle,
   output logic              busy,
   output logic              done,
   output logic              dout,
   output logic              bclk,
   output logic              strobe
);

   localparam int unsigned CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(WORD_W - 1);

   dcs_state_e        st_q, st_d;
   logic [WORD_W-1:0] sh_q, sh_d;
   logic [CNT_W-1:0]  bit_q, bit_d;
   logic              done_d;

   assign running = (st_q != ST_IDLE);
   assign idle    = (st_q == ST_IDLE);

   always_comb begin
      st_d   = st_q;
      sh_d   = sh_q;
      bit_d  = bit_q;
      done_d = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               st_d  = ST_LEAD;
               sh_d  = word;
               bit_d = FIRST_BIT;
            end
         end
         ST_LEAD:  if (tick) st_d = ST_SETUP;
         ST_SETUP: if (tick) st_d = ST_HIGH;
         ST_HIGH:  if (tick) st_d = ST_LOW;
         ST_LOW: begin
            if (tick) begin
               if (bit_q == '0) begin
                  st_d = ST_LATCH;
               end else begin
                  st_d  = ST_SETUP;
                  sh_d  = {sh_q[WORD_W-2:0], 1'b0};
                  bit_d = bit_q - 1'b1;
               end
            end
         end
         ST_LATCH: begin
            if (tick) begin
               st_d   = ST_IDLE;
               done_d = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   // pins are registered from the next state so they change with the state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         sh_q   <= '0;
         bit_q  <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
         dout   <= 1'b0;
         bclk   <= 1'b0;
         strobe <= 1'b1;
      end else begin
         st_q   <= st_d;
         sh_q   <= sh_d;
         bit_q  <= bit_d;
         busy   <= (st_d != ST_IDLE);
         done   <= done_d;
         dout   <= ((st_d == ST_SETUP) || (st_d == ST_HIGH) || (st_d == ST_LOW))
                   ? sh_d[WORD_W-1] : 1'b0;
         bclk   <= (st_d == ST_HIGH);
         strobe <= (st_d != ST_LATCH);
      end
   end

endmodule

// File: rtl/dac_ctl_serializer.sv
module dac_ctl_serializer #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned IDX_W      = 2,
   parameter int unsigned IDX_LSB    = 9,
   parameter int unsigned PAY_W      = 9,
   parameter int unsigned PHASE_CLKS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [IDX_W-1:0] req_idx,
   input  logic [PAY_W-1:0] req_data,
   output logic             busy,
   output logic             done,
   output logic             dac_dout,
   output logic             dac_bclk,
   output logic             dac_strobe
);

   generate
      if (PHASE_CLKS < 1) begin : g_bad_phase
         $error("PHASE_CLKS must be at least 1");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
      if (IDX_LSB + IDX_W > WORD_W) begin : g_bad_idx
         $error("index field does not fit in the word");
      end
      if (PAY_W > WORD_W) begin : g_bad_pay
         $error("payload wider than the word");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              tick;
   logic              running;
   logic              idle;
   logic              start;

   assign req_ready = idle;
   assign start     = req_valid && idle;

   dcs_word_form #(
      .WORD_W  (WORD_W),
      .IDX_W   (IDX_W),
      .IDX_LSB (IDX_LSB),
      .PAY_W   (PAY_W)
   ) u_form (
      .idx  (req_idx),
      .pay  (req_data),
      .word (word)
   );

   dcs_phase_timer #(
      .PHASE_CLKS (PHASE_CLKS)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (running),
      .tick  (tick)
   );

   dcs_shift_fsm #(
      .WORD_W (WORD_W)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .word    (word),
      .tick    (tick),
      .running (running),
      .idle    (idle),
      .busy    (busy),
      .done    (done),
      .dout    (dac_dout),
      .bclk    (dac_bclk),
      .strobe  (dac_strobe)
   );

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
   parameter int unsigned PHASE_CLKS = 4
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic busy,
   input logic done,
   input logic dac_dout,
   input logic dac_bclk,
   input logic dac_strobe
);

   logic [15:0] low_run;
   logic [15:0] high_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= '0;
         high_run <= '0;
      end else begin
         low_run  <= (!dac_strobe && low_run  != 16'hFFFF) ? low_run  + 1'b1 : '0;
         high_run <= ( dac_bclk   && high_run != 16'hFFFF) ? high_run + 1'b1 : '0;
      end
   end

   // R7: an accepted request makes the block busy on the next cycle
   assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);

   // R7: no acceptance is possible while busy
   assert_no_ready_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);

   // R8: done lasts one cycle
   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: done coincides with strobe high, busy low, and the strobe just rose
   assert_done_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (dac_strobe && !busy && $rose(dac_strobe)));

   // R3: data does not change while the bit clock is high
   assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dac_bclk |-> $stable(dac_dout));

   // R5: strobe low only during a transfer and never with the bit clock high
   assert_strobe_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_strobe |-> (busy && !dac_bclk));

   // R6: strobe low pulse lasts one phase
   assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_strobe) |-> (low_run == 16'(PHASE_CLKS)));

   // R6: bit clock high lasts one phase
   assert_bclk_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_bclk) |-> (high_run == 16'(PHASE_CLKS)));

   // R9: idle pins when not busy
   assert_idle_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dac_strobe && !dac_bclk && !dac_dout));

endmodule

bind dac_ctl_serializer dcs_checker #(.PHASE_CLKS(PHASE_CLKS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .busy       (busy),
   .done       (done),
   .dac_dout   (dac_dout),
   .dac_bclk   (dac_bclk),
   .dac_strobe (dac_strobe)
);

// File: tb/sim_dac_ctl_serializer.sv
module sim_dac_ctl_serializer;

   localparam int P0 = 1;
   localparam int P1 = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       vld [2];
   logic [1:0] idx [2];
   logic [8:0] dat [2];
   logic       rdy [2];
   logic       bsy [2];
   logic       dn  [2];
   logic       dout[2];
   logic       bck [2];
   logic       stb [2];

   int checks = 0;
   int fails  = 0;

   dac_ctl_serializer #(.PHASE_CLKS(P0)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(vld[0]), .req_ready(rdy[0]),
      .req_idx(idx[0]), .req_data(dat[0]), .busy(bsy[0]), .done(dn[0]),
      .dac_dout(dout[0]), .dac_bclk(bck[0]), .dac_strobe(stb[0]));

   dac_ctl_serializer #(.PHASE_CLKS(P1)) u1 (
      .clk(clk), .rst_n(rst_n), .req_valid(vld[1]), .req_ready(rdy[1]),
      .req_idx(idx[1]), .req_data(dat[1]), .busy(bsy[1]), .done(dn[1]),
      .dac_dout(dout[1]), .dac_bclk(bck[1]), .dac_strobe(stb[1]));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input int k, input int p, input int ix, input int pay, input bit intrude);
      int n = 0, bits = 0, hi = 0, lo = 0, early = 0, unstable = 0;
      int rdy_bad = 0, first_rise = 0;
      logic [15:0] got = '0;
      logic prev_clk = 1'b0, cap = 1'b0;
      int exp_word = ix * 512 + pay;
      @(negedge clk);
      chk(rdy[k] == 1'b1, "R7 ready before request", int'(rdy[k]), 1);
      vld[k] = 1'b1; idx[k] = 2'(ix); dat[k] = 9'(pay);
      @(posedge clk);
      do begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            // R4 lead-in phase
            chk(dout[k] == 0 && bck[k] == 0 && stb[k] == 1, "R4 lead-in pins",
                int'({dout[k], bck[k], stb[k]}), 1);
            chk(bsy[k] == 1, "R7 busy after accept", int'(bsy[k]), 1);
            if (intrude) begin
               vld[k] = 1'b1; idx[k] = ~2'(ix); dat[k] = ~9'(pay);
            end else begin
               vld[k] = 1'b0;
            end
         end
         if (bck[k] && !prev_clk) begin
            got = {got[14:0], dout[k]};
            cap = dout[k];
            bits++;
            if (bits == 1) first_rise = n;
         end
         if (!bck[k] && prev_clk && dout[k] != cap) unstable++;
         if (bck[k]) hi++;
         if (!stb[k]) begin
            lo++;
            if (bits != 16 || bck[k]) early++;
         end
         if (bsy[k] && rdy[k]) rdy_bad++;
         prev_clk = bck[k];
      end while (!dn[k] && n < 60 * p + 10);
      vld[k] = 1'b0;
      chk(got == 16'(exp_word), "R1 word value", int'(got), exp_word);
      chk(bits == 16, "R2 bit count", bits, 16);
      chk(unstable == 0, "R3 data held across bit", unstable, 0);
      chk(first_rise == 2 * p + 1, "R4 first rising edge position", first_rise, 2 * p + 1);
      chk(lo == p && early == 0, "R5 strobe pulse", lo * 100 + early, p * 100);
      chk(hi == 16 * p, "R6 bit clock high cycles", hi, 16 * p);
      chk(n == 50 * p + 1, "R6 transfer length", n, 50 * p + 1);
      chk(rdy_bad == 0, "R7 ready low while busy", rdy_bad, 0);
      chk(dn[k] && stb[k] && !bsy[k] && rdy[k], "R8 done with strobe high",
          int'({dn[k], stb[k], bsy[k], rdy[k]}), 'b1101);
      @(negedge clk);
      chk(dn[k] == 0, "R8 done single cycle", int'(dn[k]), 0);
      chk(bsy[k] == 0, "R7 no accept from held request", int'(bsy[k]), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int k = 0; k < 2; k++) begin
         vld[k] = 1'b0; idx[k] = '0; dat[k] = '0;
      end
      repeat (3) @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         chk(stb[k] == 1 && dout[k] == 0 && bck[k] == 0, "R9 reset pins",
             int'({stb[k], dout[k], bck[k]}), 'b100);
         chk(bsy[k] == 0 && dn[k] == 0 && rdy[k] == 1, "R9 reset flags",
             int'({bsy[k], dn[k], rdy[k]}), 'b001);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // exhaustive index/payload sweep on the single-clock-phase copy
      for (int ix = 0; ix < 4; ix++) begin
         for (int pay = 0; pay < 512; pay++) begin
            send(0, P0, ix, pay, (pay % 97) == 5);
         end
      end
      // phase timing on the three-clock-phase copy
      send(1, P1, 3, 511, 1'b0);
      send(1, P1, 0, 0, 1'b0);
      send(1, P1, 2, 170, 1'b1);
      send(1, P1, 1, 341, 1'b0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule